// File: doc/BRIEF.md
# Multi-Cycle Instruction Cycle Sequencer

This block is the control unit and register set of a small accumulator machine. It runs each instruction as a series of subcycles: fetch, an optional indirect subcycle, execute, and an optional interrupt-entry subcycle. In each state it drives the transfers among the program counter (PC), memory address register (MAR), memory buffer register (MBR), instruction register (IR) and accumulator (AC). It reaches a single-ported memory through read and write strobes. Each strobe is held until the memory raises its ready input.

Instruction words are `DW` bits wide. The top 3 bits are the opcode. The next bit selects indirect addressing. The low `AW` bits are the address field. The execute subcycle supports load, store, add and jump. Interrupt entry stores the return PC at a fixed save location and moves the PC to a fixed handler vector. It also pulses a request that the owner of the interrupt-enable flag clear it.

Top module: `instr_cycle_seq`

## Requirements
- R1: While reset is asserted, `pc_o` equals `RESET_PC`, `phase_o` is 0 (fetch), and both memory strobes are low.
- R2: Fetch reads the word at the address held in the PC and loads it into the IR. When that read completes, the PC becomes PC+1.
- R3: Instruction layout is [15:13] opcode, [12] indirect, [11:0] address. With bit 12 set, an indirect subcycle reads the word at the address field, and the low 12 bits of that word become the effective address. With bit 12 clear, no indirect subcycle runs and the address field is the effective address.
- R4: Opcode 3'b001 (load) sets AC to the word at the effective address. Opcode 3'b011 (add) sets AC to AC plus that word, modulo 2^16.
- R5: Opcode 3'b010 (store) writes AC to the effective address.
- R6: Opcode 3'b100 (jump) sets the PC to the effective address. The next fetch is taken from there. Opcodes 3'b000, 3'b101, 3'b110 and 3'b111 change neither AC nor memory.
- R7: Every memory access holds its strobe, address and write data unchanged until `mem_ready_i` is high. Read and write strobes are never high together.
- R8: If `irq_i` and `ie_i` are both high at the end of execute, the block writes the return PC to `SAVE_ADDR` (default 12'h000), loads the PC with `VEC_ADDR` (default 12'h001), and pulses `ie_clr_o` for one cycle. The next fetch is taken from `VEC_ADDR`.
- R9: While `ie_i` is low, `irq_i` has no effect: no interrupt subcycle runs and nothing is written to the save location.
- R10: `phase_o` reports the current subcycle: 0 fetch, 1 indirect, 2 execute, 3 interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_ready_i | input | 1 | Memory has completed the current access |
| mem_rdata_i | input | DW | Memory read data |
| irq_i | input | 1 | Interrupt request |
| ie_i | input | 1 | Interrupt-enable flag |
| mem_addr_o | output | AW | Memory address (MAR) |
| mem_wdata_o | output | DW | Memory write data (MBR) |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| pc_ld_o | output | 1 | PC load enable |
| mar_ld_o | output | 1 | MAR load enable |
| mbr_ld_o | output | 1 | MBR load enable |
| ir_ld_o | output | 1 | IR load enable |
| ac_ld_o | output | 1 | AC load enable |
| ie_clr_o | output | 1 | One-cycle request to clear the interrupt-enable flag |
| pc_o | output | AW | Program counter |
| ac_o | output | DW | Accumulator |
| phase_o | output | 2 | Current subcycle |

## Verification
The bench targets these corner cases:
- **Add carry-out.** An add that carries out of bit 15 must wrap to 1. A design that widened or saturated the sum would not.
- **Jump.** After a jump, the word right after it must never be fetched. A design that let the fetch increment win over the jump target would fetch it.
- **Indirect and undefined opcodes.** An indirect load through a pointer word runs under wait states. An undefined opcode follows it. A design that skipped the indirect read would load the pointer rather than the data. A design that treated the undefined opcode as a store would overwrite memory.
- **Held store and interrupts.** With three wait states, a store must hold its write strobe for exactly four cycles. Interrupt entry must save the PC of the instruction after the one that just completed, and must fire once only. Interrupt entry must not occur while the enable flag is low.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int OP_W = 3;

  localparam logic [OP_W-1:0] OPC_LOAD  = 3'd1;
  localparam logic [OP_W-1:0] OPC_STORE = 3'd2;
  localparam logic [OP_W-1:0] OPC_ADD   = 3'd3;
  localparam logic [OP_W-1:0] OPC_JUMP  = 3'd4;

  typedef enum logic [1:0] {PH_FETCH = 2'd0, PH_IND = 2'd1, PH_EXEC = 2'd2, PH_INT = 2'd3} phase_e;
  typedef enum logic [1:0] {PC_INC, PC_EA, PC_VEC} pc_sel_e;
  typedef enum logic [1:0] {MAR_PC, MAR_EA, MAR_SAVE} mar_sel_e;
  typedef enum logic [1:0] {MBR_RD, MBR_AC, MBR_PC} mbr_sel_e;

  typedef enum logic [3:0] {
    S_F_ADDR, S_F_READ, S_F_IR,
    S_I_ADDR, S_I_READ,
    S_E_ADDR, S_E_READ, S_E_ACC, S_E_WRITE,
    S_X_SAVE, S_X_WRITE, S_X_VEC
  } state_e;

  typedef struct packed {
    logic     pc_ld;
    pc_sel_e  pc_sel;
    logic     mar_ld;
    mar_sel_e mar_sel;
    logic     mbr_ld;
    mbr_sel_e mbr_sel;
    logic     ir_ld;
    logic     ac_ld;
    logic     ac_add;
  } ctrl_t;
endpackage

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter logic [AW-1:0] RESET_PC  = 12'h010,
  parameter logic [AW-1:0] SAVE_ADDR = 12'h000,
  parameter logic [AW-1:0] VEC_ADDR  = 12'h001
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ctrl_t         ctrl_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] mar_o,
  output logic [DW-1:0] mbr_o,
  output logic [DW-1:0] ir_o,
  output logic [DW-1:0] ac_o
);
  localparam int PAD_W = DW - AW;

  logic [AW-1:0] pc_q, mar_q;
  logic [DW-1:0] mbr_q, ir_q, ac_q;
  logic [AW-1:0] ea;

  assign ea = mbr_q[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= RESET_PC;
      mar_q <= '0;
      mbr_q <= '0;
      ir_q  <= '0;
      ac_q  <= '0;
    end else begin
      if (ctrl_i.pc_ld) begin
        unique case (ctrl_i.pc_sel)
          PC_INC:  pc_q <= pc_q + 1'b1;
          PC_EA:   pc_q <= ea;
          PC_VEC:  pc_q <= VEC_ADDR;
          default: pc_q <= pc_q;
        endcase
      end
      if (ctrl_i.mar_ld) begin
        unique case (ctrl_i.mar_sel)
          MAR_PC:   mar_q <= pc_q;
          MAR_EA:   mar_q <= ea;
          MAR_SAVE: mar_q <= SAVE_ADDR;
          default:  mar_q <= mar_q;
        endcase
      end
      if (ctrl_i.mbr_ld) begin
        unique case (ctrl_i.mbr_sel)
          MBR_RD:  mbr_q <= rdata_i;
          MBR_AC:  mbr_q <= ac_q;
          MBR_PC:  mbr_q <= {{PAD_W{1'b0}}, pc_q};
          default: mbr_q <= mbr_q;
        endcase
      end
      if (ctrl_i.ir_ld) ir_q <= mbr_q;
      if (ctrl_i.ac_ld) ac_q <= ctrl_i.ac_add ? ac_q + mbr_q : mbr_q;
    end
  end

  assign pc_o  = pc_q;
  assign mar_o = mar_q;
  assign mbr_o = mbr_q;
  assign ir_o  = ir_q;
  assign ac_o  = ac_q;
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import seq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ready_i,
  input  logic            irq_i,
  input  logic            ie_i,
  input  logic            ind_i,
  input  logic [OP_W-1:0] op_i,
  output ctrl_t           ctrl_o,
  output logic            rd_o,
  output logic            wr_o,
  output logic            ie_clr_o,
  output logic [1:0]      phase_o
);
  state_e state_q, state_d;
  logic   last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_F_ADDR;
    else         state_q <= state_d;
  end

  always_comb begin
    ctrl_o   = '0;
    rd_o     = 1'b0;
    wr_o     = 1'b0;
    ie_clr_o = 1'b0;
    last     = 1'b0;
    state_d  = state_q;
    unique case (state_q)
      S_F_ADDR: begin
        ctrl_o.mar_ld  = 1'b1;
        ctrl_o.mar_sel = MAR_PC;
        state_d        = S_F_READ;
      end
      S_F_READ: begin
        rd_o = 1'b1;
        if (ready_i) begin
          ctrl_o.mbr_ld = 1'b1;
          ctrl_o.mbr_sel = MBR_RD;
          ctrl_o.pc_ld  = 1'b1;
          ctrl_o.pc_sel = PC_INC;
          state_d       = S_F_IR;
        end
      end
      S_F_IR: begin
        ctrl_o.ir_ld = 1'b1;
        state_d      = ind_i ? S_I_ADDR : S_E_ADDR;
      end
      S_I_ADDR: begin
        ctrl_o.mar_ld  = 1'b1;
        ctrl_o.mar_sel = MAR_EA;
        state_d        = S_I_READ;
      end
      S_I_READ: begin
        rd_o = 1'b1;
        if (ready_i) begin
          ctrl_o.mbr_ld  = 1'b1;
          ctrl_o.mbr_sel = MBR_RD;
          state_d        = S_E_ADDR;
        end
      end
      S_E_ADDR: begin
        ctrl_o.mar_ld  = 1'b1;
        ctrl_o.mar_sel = MAR_EA;
        if (op_i == OPC_LOAD || op_i == OPC_ADD) begin
          state_d = S_E_READ;
        end else if (op_i == OPC_STORE) begin
          ctrl_o.mbr_ld  = 1'b1;
          ctrl_o.mbr_sel = MBR_AC;
          state_d        = S_E_WRITE;
        end else if (op_i == OPC_JUMP) begin
          ctrl_o.pc_ld  = 1'b1;
          ctrl_o.pc_sel = PC_EA;
          last          = 1'b1;
        end else begin
          last = 1'b1;
        end
      end
      S_E_READ: begin
        rd_o = 1'b1;
        if (ready_i) begin
          ctrl_o.mbr_ld  = 1'b1;
          ctrl_o.mbr_sel = MBR_RD;
          state_d        = S_E_ACC;
        end
      end
      S_E_ACC: begin
        ctrl_o.ac_ld  = 1'b1;
        ctrl_o.ac_add = (op_i == OPC_ADD);
        last          = 1'b1;
      end
      S_E_WRITE: begin
        wr_o = 1'b1;
        last = ready_i;
      end
      S_X_SAVE: begin
        ctrl_o.mbr_ld  = 1'b1;
        ctrl_o.mbr_sel = MBR_PC;
        ctrl_o.mar_ld  = 1'b1;
        ctrl_o.mar_sel = MAR_SAVE;
        state_d        = S_X_WRITE;
      end
      S_X_WRITE: begin
        wr_o = 1'b1;
        if (ready_i) state_d = S_X_VEC;
      end
      S_X_VEC: begin
        ctrl_o.pc_ld  = 1'b1;
        ctrl_o.pc_sel = PC_VEC;
        ie_clr_o      = 1'b1;
        state_d       = S_F_ADDR;
      end
      default: state_d = S_F_ADDR;
    endcase
    // end of execute: interrupt check
    if (last) state_d = (irq_i && ie_i) ? S_X_SAVE : S_F_ADDR;
  end

  always_comb begin
    unique case (state_q)
      S_F_ADDR, S_F_READ, S_F_IR:                   phase_o = PH_FETCH;
      S_I_ADDR, S_I_READ:                           phase_o = PH_IND;
      S_E_ADDR, S_E_READ, S_E_ACC, S_E_WRITE:       phase_o = PH_EXEC;
      default:                                      phase_o = PH_INT;
    endcase
  end
endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq
  import seq_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter logic [AW-1:0] RESET_PC  = 12'h010,
  parameter logic [AW-1:0] SAVE_ADDR = 12'h000,
  parameter logic [AW-1:0] VEC_ADDR  = 12'h001
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mem_ready_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          irq_i,
  input  logic          ie_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic          pc_ld_o,
  output logic          mar_ld_o,
  output logic          mbr_ld_o,
  output logic          ir_ld_o,
  output logic          ac_ld_o,
  output logic          ie_clr_o,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] ac_o,
  output logic [1:0]    phase_o
);
  localparam int OP_LSB = DW - OP_W;

  ctrl_t         ctrl;
  logic [DW-1:0] mbr, ir;

  seq_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ready_i  (mem_ready_i),
    .irq_i    (irq_i),
    .ie_i     (ie_i),
    .ind_i    (mbr[AW]),
    .op_i     (ir[DW-1:OP_LSB]),
    .ctrl_o   (ctrl),
    .rd_o     (mem_rd_o),
    .wr_o     (mem_wr_o),
    .ie_clr_o (ie_clr_o),
    .phase_o  (phase_o)
  );

  seq_datapath #(
    .AW(AW), .DW(DW), .RESET_PC(RESET_PC), .SAVE_ADDR(SAVE_ADDR), .VEC_ADDR(VEC_ADDR)
  ) u_dp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ctrl_i  (ctrl),
    .rdata_i (mem_rdata_i),
    .pc_o    (pc_o),
    .mar_o   (mem_addr_o),
    .mbr_o   (mbr),
    .ir_o    (ir),
    .ac_o    (ac_o)
  );

  assign mem_wdata_o = mbr;
  assign pc_ld_o     = ctrl.pc_ld;
  assign mar_ld_o    = ctrl.mar_ld;
  assign mbr_ld_o    = ctrl.mbr_ld;
  assign ir_ld_o     = ctrl.ir_ld;
  assign ac_ld_o     = ctrl.ac_ld;
endmodule

// File: rtl/seq_checker.sv
module seq_checker
  import seq_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter logic [AW-1:0] SAVE_ADDR = 12'h000,
  parameter logic [AW-1:0] VEC_ADDR  = 12'h001
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_ready_i,
  input logic          irq_i,
  input logic          ie_i,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          mem_rd_o,
  input logic          mem_wr_o,
  input logic          pc_ld_o,
  input logic          ir_ld_o,
  input logic          ie_clr_o,
  input logic [AW-1:0] pc_o,
  input logic [1:0]    phase_o
);
  assert_strobe_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  assert_rd_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && !mem_ready_i) |=> (mem_rd_o && $stable(mem_addr_o)));

  assert_wr_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && !mem_ready_i) |=> (mem_wr_o && $stable(mem_addr_o) && $stable(mem_wdata_o)));

  assert_fetch_inc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_FETCH && pc_ld_o) |=> (pc_o == AW'($past(pc_o) + 1'b1)));

  assert_ir_in_fetch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_ld_o |-> (phase_o == PH_FETCH));

  assert_save_addr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && phase_o == PH_INT) |-> (mem_addr_o == SAVE_ADDR));

  assert_vector_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ie_clr_o |=> (pc_o == VEC_ADDR && phase_o == PH_FETCH));

  assert_int_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_INT && $past(phase_o) == PH_EXEC) |-> $past(irq_i && ie_i));
endmodule

bind instr_cycle_seq seq_checker #(
  .AW(AW), .DW(DW), .SAVE_ADDR(SAVE_ADDR), .VEC_ADDR(VEC_ADDR)
) u_chk (.*);

// File: tb/tb_instr_cycle_seq.sv
`timescale 1ns/1ps
module tb_instr_cycle_seq;
  localparam int AW = 12;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ready;
  logic [DW-1:0] rdata;
  logic          irq, ie;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic          rd, wr, pc_ld, mar_ld, mbr_ld, ir_ld, ac_ld, ie_clr;
  logic [AW-1:0] pc;
  logic [DW-1:0] ac;
  logic [1:0]    phase;

  int total = 0;
  int bad   = 0;
  int lat   = 0;
  int cnt   = 0;
  int ind_seen, exe_seen, int_seen, clr_cnt, wr_cycles, watch_hit, overlap;
  logic [AW-1:0] watch_addr;
  logic [DW-1:0] mem [0:4095];

  always #10 clk = ~clk;

  instr_cycle_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .mem_ready_i(ready), .mem_rdata_i(rdata),
    .irq_i(irq), .ie_i(ie), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_rd_o(rd), .mem_wr_o(wr), .pc_ld_o(pc_ld), .mar_ld_o(mar_ld),
    .mbr_ld_o(mbr_ld), .ir_ld_o(ir_ld), .ac_ld_o(ac_ld), .ie_clr_o(ie_clr),
    .pc_o(pc), .ac_o(ac), .phase_o(phase)
  );

  // memory model with programmable wait states
  assign rdata = mem[addr];
  assign ready = (rd || wr) && (cnt >= lat);

  always @(posedge clk) begin
    if (!(rd || wr) || ready) cnt <= 0;
    else                      cnt <= cnt + 1;
    if (rst_n && wr && ready) mem[addr] = wdata;
  end

  // monitor, and owner of the enable flag
  always @(negedge clk) begin
    if (rst_n) begin
      if (phase == 2'd1) ind_seen++;
      if (phase == 2'd2) exe_seen++;
      if (phase == 2'd3) int_seen++;
      if (wr) wr_cycles++;
      if (rd && wr) overlap++;
      if (rd && phase == 2'd0 && addr == watch_addr) watch_hit++;
      if (ie_clr) begin
        clr_cnt++;
        ie = 1'b0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    ind_seen = 0; exe_seen = 0; int_seen = 0; clr_cnt = 0;
    wr_cycles = 0; watch_hit = 0; overlap = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_to(input logic [AW-1:0] target, input string tag);
    bit hit = 0;
    int n = 0;
    while (!hit && n < 2000) begin
      @(negedge clk);
      n++;
      if (rd && phase == 2'd0 && addr == target) hit = 1;
    end
    chk({tag, " reached fetch"}, 32'(hit), 32'd1);
  endtask

  task automatic t_reset();
    clear_mem();
    irq = 1'b0; ie = 1'b0; lat = 0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 pc", 32'(pc), 32'h010);
    chk("R1 phase", 32'(phase), 32'd0);
    chk("R1 strobes", {30'd0, rd, wr}, 32'd0);
  endtask

  task automatic t_direct();
    clear_mem();
    mem[12'h010] = 16'h2100; // load 0x100
    mem[12'h011] = 16'h6101; // add 0x101
    mem[12'h012] = 16'h4102; // store 0x102
    mem[12'h013] = 16'h8020; // jump 0x020
    mem[12'h100] = 16'hFFFE;
    mem[12'h101] = 16'h0003;
    irq = 1'b0; ie = 1'b0; lat = 0; watch_addr = 12'h014;
    do_reset();
    while (!ir_ld) @(negedge clk);
    chk("R2 pc incremented after fetch", 32'(pc), 32'h011);
    run_to(12'h020, "R6 jump");
    chk("R4 add wraps", 32'(ac), 32'h0001);
    chk("R5 store", 32'(mem[12'h102]), 32'h0001);
    chk("R6 no fetch after jump", 32'(watch_hit), 32'd0);
    chk("R3 direct skips indirect", 32'(ind_seen), 32'd0);
    chk("R10 execute phase seen", 32'(exe_seen > 0), 32'd1);
  endtask

  task automatic t_indirect();
    clear_mem();
    mem[12'h010] = 16'h3030; // load indirect via 0x030
    mem[12'h011] = 16'hE105; // undefined opcode 111
    mem[12'h030] = 16'h0104;
    mem[12'h104] = 16'h0055;
    mem[12'h105] = 16'hAAAA;
    irq = 1'b0; ie = 1'b0; lat = 2;
    do_reset();
    run_to(12'h012, "R3 indirect");
    chk("R3 R4 indirect load", 32'(ac), 32'h0055);
    chk("R10 indirect phase seen", 32'(ind_seen > 0), 32'd1);
    chk("R6 undefined opcode keeps memory", 32'(mem[12'h105]), 32'hAAAA);
    chk("R6 undefined opcode keeps ac", 32'(ac), 32'h0055);
  endtask

  task automatic t_wait();
    clear_mem();
    mem[12'h010] = 16'h2100;
    mem[12'h011] = 16'h4102;
    mem[12'h012] = 16'h8020;
    mem[12'h100] = 16'h1234;
    irq = 1'b0; ie = 1'b0; lat = 3;
    do_reset();
    run_to(12'h020, "R7 wait");
    chk("R7 store under wait", 32'(mem[12'h102]), 32'h1234);
    chk("R7 write held four cycles", 32'(wr_cycles), 32'd4);
    chk("R7 no rd/wr overlap", 32'(overlap), 32'd0);
  endtask

  task automatic t_irq_off();
    clear_mem();
    mem[12'h000] = 16'hBEEF;
    mem[12'h010] = 16'h2100;
    mem[12'h011] = 16'h8020;
    mem[12'h100] = 16'h0077;
    irq = 1'b1; ie = 1'b0; lat = 1;
    do_reset();
    run_to(12'h020, "R9 masked");
    chk("R9 no interrupt phase", 32'(int_seen), 32'd0);
    chk("R9 save slot untouched", 32'(mem[12'h000]), 32'h0000BEEF);
    chk("R9 no clear pulse", 32'(clr_cnt), 32'd0);
  endtask

  task automatic t_irq_on();
    clear_mem();
    mem[12'h000] = 16'hBEEF;
    mem[12'h010] = 16'h2100;
    mem[12'h100] = 16'h0042;
    irq = 1'b1; ie = 1'b1; lat = 1;
    do_reset();
    run_to(12'h001, "R8 vector");
    chk("R8 return pc saved", 32'(mem[12'h000]), 32'h0011);
    chk("R8 pc at vector", 32'(pc), 32'h001);
    chk("R8 single clear pulse", 32'(clr_cnt), 32'd1);
    chk("R8 enable dropped", 32'(ie), 32'd0);
    chk("R8 instruction completed first", 32'(ac), 32'h0042);
    chk("R10 interrupt phase seen", 32'(int_seen > 0), 32'd1);
    irq = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_direct();
    t_indirect();
    t_wait();
    t_irq_off();
    t_irq_on();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule